// File: doc/BRIEF.md
# Virtual Core Enable and Park Control

This block holds the control and status masks that decide which virtual cores of a multi-thread processor exist, which are enabled, and which are running or parked, plus a mask that steers external reset requests to cores. Software reaches it through a small register bus: a 3-bit register select, separate read and write strobes, 64-bit write and read data, and the number of the thread making the request. Every mask is one bit per virtual core, held in the low bits of the 64-bit word.

The set of present cores is fixed at build time by a parameter. The enable mask is written at any time, but it only reaches the enable-status mask, and through it the cores, at the next warm reset. The running mask is written directly or through set and clear aliases. Writable masks are clipped to the present cores, and the requesting thread can neither disable nor park itself. The block drives the effective running mask and the reset-steering mask to the cores.

Top module: `core_ctl_regs`

## Requirements
- R1: Register select codes are 0 present-cores, 1 enable, 2 enable-status, 3 running, 4 running-set alias, 5 running-clear alias, 6 running-status, 7 reset-steering; a read of code 0 returns the build-time present mask (0xFF with 8 cores), and writes to it are ignored.
- R2: After power-on reset, enable, enable-status and reset-steering read the present mask, and running and running-status read only the lowest present core.
- R3: A write to code 1 updates the enable mask; the enable-status mask (code 2) does not change until a warm reset.
- R4: Bits of cores that are not present read back as 0 in every writable mask, and bits 63 down to the core count always read 0.
- R5: An enable write never clears the requesting thread's own bit when that core is present.
- R6: A write to code 3 loads the running mask from the write data, but keeps the requesting thread's own bit set.
- R7: A write to code 4 sets every running bit where the write data holds a 1 and leaves the others.
- R8: A write to code 5 clears every running bit where the write data holds a 1, except the requesting thread's own bit.
- R9: Running-status (code 6) and the running-mask output equal present AND enable-status AND running, one clock after the running mask changes.
- R10: A write to code 7 loads the reset-steering mask, clipped to present cores, and drives it on the steering output; writing zero reads back zero.
- R11: A warm reset copies enable into enable-status and reloads running with the lowest bit of enable (zero if enable is empty); enable and steering keep their values.
- R12: With the read strobe low, and for codes 4 and 5, read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_rst | input | 1 | Warm reset pulse, sampled on the clock |
| reg_sel | input | 3 | Register select code |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| req_tid | input | TID_W (3) | Number of the requesting thread |
| rd_data | output | 64 | Read data, combinational from the select |
| run_mask_o | output | N_CORES (8) | Effective running mask to the cores |
| steer_mask_o | output | N_CORES (8) | Reset-steering mask to the cores |

## Verification
Each mask is written with all ones, all zeros and alternating or partial patterns, from different requesting threads, so that plain clipping is told apart from the forced self bit. A second copy built with a sparse present mask separates the clip from the data itself, since all-ones and alternating writes read back differently there. The set and clear aliases are given overlapping patterns to show that untouched bits survive, and a warm reset after enable writes shows the deferred copy and the running reload, including the empty-enable case.

// File: rtl/core_ctl_pkg.sv
package core_ctl_pkg;
  typedef enum logic [2:0] {
    SEL_PRESENT  = 3'd0,
    SEL_EN       = 3'd1,
    SEL_EN_STAT  = 3'd2,
    SEL_RUN      = 3'd3,
    SEL_RUN_SET  = 3'd4,
    SEL_RUN_CLR  = 3'd5,
    SEL_RUN_STAT = 3'd6,
    SEL_STEER    = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ccr_enable_unit.sv
module ccr_enable_unit #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wr_data_i,
  input  logic [N-1:0] self_i,
  input  logic         warm_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] en_stat_o
);
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] stat_q, stat_d;
  logic         en_ce, stat_ce;

  always_comb begin
    en_ce  = wr_i;
    en_d   = (wr_data_i & PRESENT) | self_i;
    stat_ce = warm_i;
    stat_d  = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= PRESENT;
      stat_q <= PRESENT;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (stat_ce) stat_q <= stat_d;
    end
  end

  assign en_o      = en_q;
  assign en_stat_o = stat_q;
endmodule

// File: rtl/ccr_run_unit.sv
module ccr_run_unit #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [N-1:0] wr_data_i,
  input  logic [N-1:0] self_i,
  input  logic         warm_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] en_stat_i,
  output logic [N-1:0] run_o,
  output logic [N-1:0] run_stat_o
);
  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    logic [N-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  localparam logic [N-1:0] RUN_RST = lowest_bit(PRESENT);

  logic [N-1:0] run_q, run_d;
  logic [N-1:0] stat_q, stat_d;
  logic         run_ce;
  logic [N-1:0] data_m;

  always_comb begin
    data_m = wr_data_i & PRESENT;
    run_ce = warm_i | wr_load_i | wr_set_i | wr_clr_i;
    run_d  = run_q;
    if (warm_i)         run_d = lowest_bit(en_i);
    else if (wr_load_i) run_d = data_m | self_i;
    else if (wr_set_i)  run_d = run_q | data_m;
    else if (wr_clr_i)  run_d = run_q & ~(data_m & ~self_i);
    stat_d = PRESENT & en_stat_i & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= RUN_RST;
      stat_q <= RUN_RST;
    end else begin
      if (run_ce) run_q <= run_d;
      stat_q <= stat_d;
    end
  end

  assign run_o      = run_q;
  assign run_stat_o = stat_q;
endmodule

// File: rtl/ccr_read_mux.sv
module ccr_read_mux
  import core_ctl_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 64
) (
  input  logic          rd_en_i,
  input  reg_sel_e      sel_i,
  input  logic [N-1:0]  present_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  en_stat_i,
  input  logic [N-1:0]  run_i,
  input  logic [N-1:0]  run_stat_i,
  input  logic [N-1:0]  steer_i,
  output logic [DW-1:0] rd_data_o
);
  logic [N-1:0] pick;

  always_comb begin
    unique case (sel_i)
      SEL_PRESENT:  pick = present_i;
      SEL_EN:       pick = en_i;
      SEL_EN_STAT:  pick = en_stat_i;
      SEL_RUN:      pick = run_i;
      SEL_RUN_STAT: pick = run_stat_i;
      SEL_STEER:    pick = steer_i;
      default:      pick = '0;
    endcase
    rd_data_o = '0;
    if (rd_en_i) rd_data_o[N-1:0] = pick;
  end
endmodule

// File: rtl/core_ctl_regs.sv
module core_ctl_regs
  import core_ctl_pkg::*;
#(
  parameter int unsigned  N_CORES = 8,
  parameter int unsigned  DW      = 64,
  parameter logic [N_CORES-1:0] PRESENT_MASK = '1,
  localparam int unsigned TID_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               warm_rst,
  input  logic [2:0]         reg_sel,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic [TID_W-1:0]   req_tid,
  output logic [DW-1:0]      rd_data,
  output logic [N_CORES-1:0] run_mask_o,
  output logic [N_CORES-1:0] steer_mask_o
);
  localparam logic [N_CORES-1:0] ONE = {{(N_CORES-1){1'b0}}, 1'b1};

  logic               rst_sync_n;
  reg_sel_e           sel;
  logic [N_CORES-1:0] data_n, self_bit;
  logic [N_CORES-1:0] en_q, en_stat_q, run_q, run_stat_q, steer_q, steer_d;
  logic               wr_en_reg, wr_load, wr_set, wr_clr, steer_ce;
  logic               unused_hi;

  assign unused_hi = ^wr_data[DW-1:N_CORES];
  assign sel       = reg_sel_e'(reg_sel);
  assign data_n    = wr_data[N_CORES-1:0];
  assign self_bit  = (ONE << req_tid) & PRESENT_MASK;

  always_comb begin
    wr_en_reg = wr_en && (sel == SEL_EN);
    wr_load   = wr_en && (sel == SEL_RUN);
    wr_set    = wr_en && (sel == SEL_RUN_SET);
    wr_clr    = wr_en && (sel == SEL_RUN_CLR);
    steer_ce  = wr_en && (sel == SEL_STEER);
    steer_d   = data_n & PRESENT_MASK;
  end

  ccr_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ccr_enable_unit #(.N(N_CORES), .PRESENT(PRESENT_MASK)) u_en (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_i      (wr_en_reg),
    .wr_data_i (data_n),
    .self_i    (self_bit),
    .warm_i    (warm_rst),
    .en_o      (en_q),
    .en_stat_o (en_stat_q)
  );

  ccr_run_unit #(.N(N_CORES), .PRESENT(PRESENT_MASK)) u_run (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_load_i  (wr_load),
    .wr_set_i   (wr_set),
    .wr_clr_i   (wr_clr),
    .wr_data_i  (data_n),
    .self_i     (self_bit),
    .warm_i     (warm_rst),
    .en_i       (en_q),
    .en_stat_i  (en_stat_q),
    .run_o      (run_q),
    .run_stat_o (run_stat_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   steer_q <= PRESENT_MASK;
    else if (steer_ce) steer_q <= steer_d;
  end

  ccr_read_mux #(.N(N_CORES), .DW(DW)) u_rd (
    .rd_en_i    (rd_en),
    .sel_i      (sel),
    .present_i  (PRESENT_MASK),
    .en_i       (en_q),
    .en_stat_i  (en_stat_q),
    .run_i      (run_q),
    .run_stat_i (run_stat_q),
    .steer_i    (steer_q),
    .rd_data_o  (rd_data)
  );

  assign run_mask_o   = run_stat_q;
  assign steer_mask_o = steer_q;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] PRESENT = '1,
  parameter int unsigned TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          warm_rst,
  input logic          wr_en,
  input logic [2:0]    reg_sel,
  input logic [N-1:0]  data_n,
  input logic [TW-1:0] req_tid,
  input logic [N-1:0]  en,
  input logic [N-1:0]  en_stat,
  input logic [N-1:0]  run,
  input logic [N-1:0]  run_out,
  input logic [N-1:0]  steer
);
  logic [N-1:0] self_c;
  assign self_c = ({{(N-1){1'b0}}, 1'b1} << req_tid) & PRESENT;

  p_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((en | run | steer | run_out) & ~PRESENT) == '0);

  p_self_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd1) |=> ((en & $past(self_c)) == $past(self_c)));

  p_self_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !warm_rst && (reg_sel == 3'd3 || (reg_sel == 3'd5 && (run & self_c) != '0)))
      |=> ((run & $past(self_c)) == $past(self_c)));

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !warm_rst && reg_sel == 3'd4)
      |=> ((run & $past(data_n & PRESENT)) == $past(data_n & PRESENT)));

  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (run_out == $past(PRESENT & en_stat & run)));

  p_stat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst |=> $stable(en_stat));

  p_warm_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (en_stat == $past(en)));
endmodule

bind core_ctl_regs ccr_checker #(.N(N_CORES), .PRESENT(PRESENT_MASK), .TW(TID_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .warm_rst (warm_rst),
  .wr_en    (wr_en),
  .reg_sel  (reg_sel),
  .data_n   (data_n),
  .req_tid  (req_tid),
  .en       (en_q),
  .en_stat  (en_stat_q),
  .run      (run_q),
  .run_out  (run_mask_o),
  .steer    (steer_q)
);

// File: tb/test_core_ctl_regs.sv
`timescale 1ns/1ps
module test_core_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n, warm_rst, rd_en, wr_en;
  logic [2:0]  reg_sel, req_tid;
  logic [63:0] wr_data, rd_a, rd_b;
  logic [7:0]  run_a, run_b, steer_a, steer_b;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  core_ctl_regs i_core_ctl_regs (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_sel(reg_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .req_tid(req_tid),
    .rd_data(rd_a), .run_mask_o(run_a), .steer_mask_o(steer_a));

  core_ctl_regs #(.PRESENT_MASK(8'h3D)) i_core_ctl_regs_sparse (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_sel(reg_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .req_tid(req_tid),
    .rd_data(rd_b), .run_mask_o(run_b), .steer_mask_o(steer_b));

  // {write sel, write data, tid, read sel, expect full, expect sparse, req}
  typedef struct packed {
    logic [2:0] wsel; logic [63:0] wdata; logic [2:0] tid;
    logic [2:0] rsel; logic [7:0] exp_a; logic [7:0] exp_b; logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    {3'd1, 64'h5555_5555_5555_5555, 3'd0, 3'd1, 8'h55, 8'h15, 4'd4},  // R4 clip of enable
    {3'd1, 64'h0,                   3'd2, 3'd1, 8'h04, 8'h04, 4'd5},  // R5 self bit kept
    {3'd1, 64'h0,                   3'd1, 3'd1, 8'h02, 8'h00, 4'd5},  // R5 absent self
    {3'd2, 64'h0,                   3'd0, 3'd2, 8'hFF, 8'h3D, 4'd3},  // R3 status deferred
    {3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd3, 8'hFF, 8'h3D, 4'd6},  // R6 all ones
    {3'd3, 64'h0,                   3'd3, 3'd3, 8'h08, 8'h08, 4'd6},  // R6 cannot park self
    {3'd4, 64'hF0,                  3'd0, 3'd3, 8'hF8, 8'h38, 4'd7},  // R7 set alias
    {3'd5, 64'hFF,                  3'd4, 3'd3, 8'h10, 8'h10, 4'd8},  // R8 clear alias
    {3'd3, 64'h81,                  3'd5, 3'd6, 8'hA1, 8'h21, 4'd9},  // R9 running status
    {3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd7, 8'hFF, 8'h3D, 4'd10}, // R10 steer clip
    {3'd7, 64'h0,                   3'd0, 3'd7, 8'h00, 8'h00, 4'd10}, // R10 steer zero
    {3'd0, 64'h0,                   3'd0, 3'd0, 8'hFF, 8'h3D, 4'd1},  // R1 read-only
    {3'd4, 64'h0,                   3'd0, 3'd3, 8'hA1, 8'h21, 4'd7}   // R7 set of nothing
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] s, input logic [63:0] d, input logic [2:0] t);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wr_data = d; req_tid = t;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(input logic [2:0] s);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = s;
    #0.5;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; warm_rst = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    reg_sel = '0; req_tid = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    do_read(3'd0); chk("R1", rd_a, 64'hFF); chk("R1", rd_b, 64'h3D);
    do_read(3'd1); chk("R2", rd_a, 64'hFF); chk("R2", rd_b, 64'h3D);
    do_read(3'd2); chk("R2", rd_a, 64'hFF);
    do_read(3'd3); chk("R2", rd_a, 64'h01);
    do_read(3'd6); chk("R2", rd_a, 64'h01);
    do_read(3'd7); chk("R2", rd_a, 64'hFF);
    chk("R2", {56'h0, run_a}, 64'h01);
    chk("R2", {56'h0, steer_b}, 64'h3D);
    rd_en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].wsel, VECS[i].wdata, VECS[i].tid);
      do_read(VECS[i].rsel);
      checks++;
      if (rd_a !== {56'h0, VECS[i].exp_a}) begin
        errors++;
        $display("FAIL R%0d vec %0d full actual=%h expected=%h", VECS[i].req, i, rd_a, VECS[i].exp_a);
      end
      checks++;
      if (rd_b !== {56'h0, VECS[i].exp_b}) begin
        errors++;
        $display("FAIL R%0d vec %0d sparse actual=%h expected=%h", VECS[i].req, i, rd_b, VECS[i].exp_b);
      end
      rd_en = 1'b0;
    end

    // R9 output port follows running status
    chk("R9", {56'h0, run_a}, 64'hA1);
    chk("R9", {56'h0, run_b}, 64'h21);
    // R10 steering output
    chk("R10", {56'h0, steer_a}, 64'h00);

    // R12 read strobe low and alias codes
    @(negedge clk); rd_en = 1'b0; reg_sel = 3'd0; #0.5;
    chk("R12", rd_a, 64'h0);
    do_read(3'd4); chk("R12", rd_a, 64'h0);
    do_read(3'd5); chk("R12", rd_a, 64'h0);
    rd_en = 1'b0;

    // R11 warm reset: enable is 0x02 full, 0x00 sparse
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    do_read(3'd2); chk("R11", rd_a, 64'h02); chk("R11", rd_b, 64'h00);
    do_read(3'd3); chk("R11", rd_a, 64'h02); chk("R11", rd_b, 64'h00);
    chk("R11", {56'h0, run_a}, 64'h02);
    do_read(3'd1); chk("R11", rd_a, 64'h02);
    do_read(3'd7); chk("R11", rd_a, 64'h00);
    rd_en = 1'b0;

    // R3 enable write after warm reset leaves status alone
    do_write(3'd1, 64'hF0, 3'd1);
    do_read(3'd2); chk("R3", rd_a, 64'h02);
    do_read(3'd1); chk("R3", rd_a, 64'hF2);
    rd_en = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule